// File: doc/BRIEF.md
# Bus Interrupter with Release on Acknowledge

This block connects a local interrupt source to a backplane that uses seven prioritised, active-low interrupt request lines and a daisy-chained acknowledge. The user side raises a request together with a priority level (1 to 7) and a 32-bit status vector. While the request is pending, the block pulls the matching request line low.

When the interrupt handler runs an acknowledge cycle, the chain input falls. The block then compares the level on address bits 3:1 with its own pending level. If the levels differ, the block passes the chain input to the chain output so that modules further down can answer. If they match, the block claims the cycle. It keeps the chain output high, presents the latched vector on the data-out bus and, one cycle later, asserts the data acknowledge. The request line is released as soon as the cycle is claimed. When the address strobe rises, the block gives the user side a single-cycle acknowledge pulse.

The strobes, the chain input and the level lines are asynchronous to the local clock, so they pass through a synchroniser of configurable depth. The pass-through path from chain input to chain output is combinational. The controller has six states:
- IDLE: no request held.
- PENDING: request held, line driven.
- PASS: cycle forwarded down the chain.
- CLAIM: vector presented.
- HOLD: data acknowledge driven.
- RELEASE: user acknowledge pulse.

The transitions are:
- IDLE→PENDING when a request with a non-zero level is seen.
- PENDING→IDLE when the request is withdrawn.
- PENDING→CLAIM on a chain falling edge with matching level.
- PENDING→PASS on a chain falling edge with a different level.
- PASS→PENDING, or PASS→IDLE if the request was dropped, when the strobe rises.
- CLAIM→HOLD unconditionally.
- HOLD→RELEASE when the strobe rises.
- RELEASE→IDLE unconditionally.

Top module: `vme_roak_interrupter`

## Requirements
- R1: After reset, all request lines are high, data acknowledge is high, the user acknowledge is low, the data-out bus is zero and the chain output follows the chain input.
- R2: A request with level L in 1..7 drives bit L-1 of `bus_irq_n` low, with all other bits high, from the first clock edge that samples the request. At most one line is low at any time.
- R3: A request with level 0 is ignored. No line is driven and the block stays idle.
- R4: Level and vector are captured when the request is accepted. Later changes on `usr_irq_lvl` or `usr_irq_vec` do not affect the driven line or the returned vector until the cycle completes.
- R5: With no request held, `bus_iackout_n` equals `bus_iackin_n` without a clock delay.
- R6: While a request is held, the chain output stays high until the decision. The decision is taken on the synchronised falling edge of the chain input while acknowledge and address strobe are both low. On a level mismatch, the chain output follows the chain input, the line stays driven and the data acknowledge stays high.
- R7: On a level match, the chain output stays high and the latched vector appears on `bus_data_out`. `bus_dtack_n` goes low one cycle after the vector appears and the request line is released.
- R8: When the address strobe rises, the data acknowledge returns high and the chain output follows the chain input again. After a claimed cycle, `usr_irq_ack` is high for exactly one cycle, directly after the data acknowledge. After a forwarded cycle, no pulse occurs.
- R9: If the user drops the request while it is held and not claimed, the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| usr_irq_req | input | 1 | User interrupt request, held until `usr_irq_ack` |
| usr_irq_lvl | input | 3 | Requested priority level, 0 means none |
| usr_irq_vec | input | 32 | Status vector returned on acknowledge |
| usr_irq_ack | output | 1 | One-cycle pulse when a claimed cycle ends |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_iack_n | input | 1 | Acknowledge cycle marker, active low |
| bus_iackin_n | input | 1 | Daisy-chain input, active low |
| bus_ack_lvl | input | 3 | Address bits 3:1, level being acknowledged |
| bus_iackout_n | output | 1 | Daisy-chain output, active low |
| bus_irq_n | output | 7 | Request lines, bit L-1 is level L, active low |
| bus_data_out | output | 32 | Vector during a claimed cycle, else zero |
| bus_dtack_n | output | 1 | Data acknowledge, active low |

## Verification
The properties assume a well-formed acknowledge cycle. The address strobe and acknowledge marker fall before the chain input falls, the level on the address bits stays steady while the strobe is low, and all three rise together at the end. They also assume the user holds its request until it sees the acknowledge pulse. The stimulus respects these rules: each cycle sets level, strobe and marker on one clock, lowers the chain input on the next, and waits several clocks before raising everything together. The user request is dropped only in the sampling slot where the pulse is seen, or deliberately while pending to exercise withdrawal.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PENDING,
        ST_PASS,
        ST_CLAIM,
        ST_HOLD,
        ST_RELEASE
    } irqr_state_e;

endpackage

// File: rtl/irqr_sync.sv
// Multi-stage synchroniser for asynchronous backplane inputs.
module irqr_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/irqr_line_drv.sv
// Decodes the held level into one active-low request line.
module irqr_line_drv #(
    parameter int LVL_W = 3,
    parameter int LINES = 7
) (
    input  logic             drive,
    input  logic [LVL_W-1:0] level,
    output logic [LINES-1:0] line_n
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            assign line_n[g] = ~(drive && (level == LVL_W'(g + 1)));
        end
    endgenerate

endmodule

// File: rtl/irqr_fsm.sv
// Interrupter sequencing: accept, arbitrate on the chain, claim, release.
module irqr_fsm
    import irqr_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usr_req,
    input  logic [LVL_W-1:0] usr_lvl,
    input  logic [VEC_W-1:0] usr_vec,
    input  logic             as_s,
    input  logic             iack_s,
    input  logic             iackin_s,
    input  logic [LVL_W-1:0] ack_lvl_s,
    input  logic             iackin_raw,
    output logic             drive_irq,
    output logic [LVL_W-1:0] held_lvl,
    output logic             iackout_n,
    output logic             dtack_n,
    output logic [VEC_W-1:0] data_out,
    output logic             usr_ack
);

    irqr_state_e state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic             iackin_prev_q;
    logic             chain_fall;
    logic             accept;

    assign chain_fall = iackin_prev_q && !iackin_s;
    assign accept     = (state_q == ST_IDLE) && usr_req && (usr_lvl != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Edge history of the synchronised chain input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iackin_prev_q <= 1'b1;
        end else begin
            iackin_prev_q <= iackin_s;
        end
    end

    // Level and vector captured on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            vec_q <= '0;
        end else if (accept) begin
            lvl_q <= usr_lvl;
            vec_q <= usr_vec;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (!usr_req) begin
                    state_d = ST_IDLE;
                end else if (chain_fall && !iack_s && !as_s) begin
                    state_d = (ack_lvl_s == lvl_q) ? ST_CLAIM : ST_PASS;
                end
            end
            ST_PASS: begin
                if (as_s) state_d = usr_req ? ST_PENDING : ST_IDLE;
            end
            ST_CLAIM: begin
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (as_s) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        drive_irq = 1'b0;
        iackout_n = iackin_raw;
        dtack_n   = 1'b1;
        data_out  = '0;
        usr_ack   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PENDING: begin
                drive_irq = 1'b1;
                iackout_n = 1'b1;
            end
            ST_PASS: begin
                drive_irq = 1'b1;
            end
            ST_CLAIM: begin
                iackout_n = 1'b1;
                data_out  = vec_q;
            end
            ST_HOLD: begin
                iackout_n = 1'b1;
                data_out  = vec_q;
                dtack_n   = 1'b0;
            end
            ST_RELEASE: begin
                usr_ack = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign held_lvl = lvl_q;

endmodule

// File: rtl/vme_roak_interrupter.sv
module vme_roak_interrupter #(
    parameter int LVL_W       = 3,
    parameter int VEC_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      usr_irq_req,
    input  logic [LVL_W-1:0]          usr_irq_lvl,
    input  logic [VEC_W-1:0]          usr_irq_vec,
    output logic                      usr_irq_ack,
    input  logic                      bus_as_n,
    input  logic                      bus_iack_n,
    input  logic                      bus_iackin_n,
    input  logic [LVL_W-1:0]          bus_ack_lvl,
    output logic                      bus_iackout_n,
    output logic [(2**LVL_W)-2:0]     bus_irq_n,
    output logic [VEC_W-1:0]          bus_data_out,
    output logic                      bus_dtack_n
);

    localparam int LINES  = (2 ** LVL_W) - 1;
    localparam int SYNC_W = LVL_W + 3;

    logic [SYNC_W-1:0] sync_q;
    logic              as_s, iack_s, iackin_s;
    logic [LVL_W-1:0]  ack_lvl_s;
    logic              drive_irq;
    logic [LVL_W-1:0]  held_lvl;

    irqr_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({bus_as_n, bus_iack_n, bus_iackin_n, bus_ack_lvl}),
        .q_out (sync_q)
    );

    assign {as_s, iack_s, iackin_s, ack_lvl_s} = sync_q;

    irqr_fsm #(
        .LVL_W (LVL_W),
        .VEC_W (VEC_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .usr_req    (usr_irq_req),
        .usr_lvl    (usr_irq_lvl),
        .usr_vec    (usr_irq_vec),
        .as_s       (as_s),
        .iack_s     (iack_s),
        .iackin_s   (iackin_s),
        .ack_lvl_s  (ack_lvl_s),
        .iackin_raw (bus_iackin_n),
        .drive_irq  (drive_irq),
        .held_lvl   (held_lvl),
        .iackout_n  (bus_iackout_n),
        .dtack_n    (bus_dtack_n),
        .data_out   (bus_data_out),
        .usr_ack    (usr_irq_ack)
    );

    irqr_line_drv #(
        .LVL_W (LVL_W),
        .LINES (LINES)
    ) u_lines (
        .drive  (drive_irq),
        .level  (held_lvl),
        .line_n (bus_irq_n)
    );

endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
    parameter int LINES = 7,
    parameter int VEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] bus_irq_n,
    input logic             bus_dtack_n,
    input logic             bus_iackout_n,
    input logic [VEC_W-1:0] bus_data_out,
    input logic             usr_irq_ack
);

    a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_irq_n) <= 1);

    a_r7_dtack_blocks_chain: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_dtack_n |-> bus_iackout_n);

    a_r7_line_released: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_dtack_n |-> (&bus_irq_n));

    a_r7_vector_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_dtack_n && $past(!bus_dtack_n)) |-> $stable(bus_data_out));

    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        usr_irq_ack |=> !usr_irq_ack);

    a_r8_ack_after_dtack: assert property (@(posedge clk) disable iff (!rst_n)
        usr_irq_ack |-> $past(!bus_dtack_n));

endmodule

bind vme_roak_interrupter irqr_chk #(
    .LINES ((2 ** LVL_W) - 1),
    .VEC_W (VEC_W)
) u_irqr_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_irq_n     (bus_irq_n),
    .bus_dtack_n   (bus_dtack_n),
    .bus_iackout_n (bus_iackout_n),
    .bus_data_out  (bus_data_out),
    .usr_irq_ack   (usr_irq_ack)
);

// File: tb/test_vme_roak_interrupter.sv
`timescale 1ns/1ps
module test_vme_roak_interrupter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usr_irq_req = 1'b0;
    logic [2:0]  usr_irq_lvl = '0;
    logic [31:0] usr_irq_vec = '0;
    logic        usr_irq_ack;
    logic        bus_as_n = 1'b1;
    logic        bus_iack_n = 1'b1;
    logic        bus_iackin_n = 1'b1;
    logic [2:0]  bus_ack_lvl = '0;
    logic        bus_iackout_n;
    logic [6:0]  bus_irq_n;
    logic [31:0] bus_data_out;
    logic        bus_dtack_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vme_roak_interrupter i_vme_roak_interrupter (
        .clk           (clk),
        .rst_n         (rst_n),
        .usr_irq_req   (usr_irq_req),
        .usr_irq_lvl   (usr_irq_lvl),
        .usr_irq_vec   (usr_irq_vec),
        .usr_irq_ack   (usr_irq_ack),
        .bus_as_n      (bus_as_n),
        .bus_iack_n    (bus_iack_n),
        .bus_iackin_n  (bus_iackin_n),
        .bus_ack_lvl   (bus_ack_lvl),
        .bus_iackout_n (bus_iackout_n),
        .bus_irq_n     (bus_irq_n),
        .bus_data_out  (bus_data_out),
        .bus_dtack_n   (bus_dtack_n)
    );

    // Rows: pending level [37:35], acknowledged level [34:32], vector [31:0]
    localparam int ROWS = 6;
    localparam logic [37:0] TBL [ROWS] = '{
        {3'd1, 3'd1, 32'hA5A5_0001},
        {3'd7, 3'd7, 32'h1234_5677},
        {3'd4, 3'd2, 32'hDEAD_0004},
        {3'd5, 3'd5, 32'h0F0F_F0F0},
        {3'd2, 3'd6, 32'hCAFE_0002},
        {3'd3, 3'd3, 32'h8000_0003}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] line_for(input logic [2:0] lvl);
        return (lvl == 3'd0) ? 7'h7f : ~(7'd1 << (lvl - 3'd1));
    endfunction

    task automatic start_cycle(input logic [2:0] lvl);
        @(negedge clk);
        bus_ack_lvl = lvl;
        bus_as_n    = 1'b0;
        bus_iack_n  = 1'b0;
        @(negedge clk);
        bus_iackin_n = 1'b0;
        #0.5;
    endtask

    // Ends the cycle and counts acknowledge pulses; drops the request when one is seen.
    task automatic end_cycle(output int pulses);
        pulses = 0;
        @(negedge clk);
        bus_as_n     = 1'b1;
        bus_iack_n   = 1'b1;
        bus_iackin_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (usr_irq_ack) begin
                pulses++;
                usr_irq_req = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int pulses;
        logic [2:0]  pl, al;
        logic [31:0] vv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq lines", {25'd0, bus_irq_n}, 32'h7f);
        check("R1 dtack", {31'd0, bus_dtack_n}, 32'd1);
        check("R1 user ack", {31'd0, usr_irq_ack}, 32'd0);
        check("R1 data out", bus_data_out, 32'd0);
        check("R1 chain out", {31'd0, bus_iackout_n}, 32'd1);

        // Table-driven acknowledge cycles
        for (int r = 0; r < ROWS; r++) begin
            pl = TBL[r][37:35];
            al = TBL[r][34:32];
            vv = TBL[r][31:0];
            @(negedge clk);
            usr_irq_req = 1'b1;
            usr_irq_lvl = pl;
            usr_irq_vec = vv;
            @(negedge clk);
            check("R2 line for level", {25'd0, bus_irq_n}, {25'd0, line_for(pl)});
            start_cycle(al);
            check("R6 chain held before decision", {31'd0, bus_iackout_n}, 32'd1);
            repeat (6) @(negedge clk);
            if (pl == al) begin
                check("R7 chain blocked", {31'd0, bus_iackout_n}, 32'd1);
                check("R7 vector", bus_data_out, vv);
                check("R7 dtack", {31'd0, bus_dtack_n}, 32'd0);
                check("R7 line released", {25'd0, bus_irq_n}, 32'h7f);
                end_cycle(pulses);
                check("R8 one ack pulse", pulses, 32'd1);
            end else begin
                check("R6 chain forwarded", {31'd0, bus_iackout_n}, 32'd0);
                check("R6 no dtack", {31'd0, bus_dtack_n}, 32'd1);
                check("R6 line still driven", {25'd0, bus_irq_n}, {25'd0, line_for(pl)});
                end_cycle(pulses);
                check("R8 no pulse after pass", pulses, 32'd0);
                check("R6 line held after pass", {25'd0, bus_irq_n}, {25'd0, line_for(pl)});
                @(negedge clk);
                usr_irq_req = 1'b0;
                repeat (2) @(negedge clk);
                check("R9 withdraw releases line", {25'd0, bus_irq_n}, 32'h7f);
            end
            check("R8 dtack released", {31'd0, bus_dtack_n}, 32'd1);
            check("R8 chain follows", {31'd0, bus_iackout_n}, 32'd1);
        end

        // R3: level 0 ignored
        @(negedge clk);
        usr_irq_req = 1'b1;
        usr_irq_lvl = 3'd0;
        repeat (3) @(negedge clk);
        check("R3 level zero no line", {25'd0, bus_irq_n}, 32'h7f);
        // R5: still idle, chain passes straight through
        bus_iackin_n = 1'b0;
        #0.5;
        check("R5 idle pass-through low", {31'd0, bus_iackout_n}, 32'd0);
        bus_iackin_n = 1'b1;
        #0.5;
        check("R5 idle pass-through high", {31'd0, bus_iackout_n}, 32'd1);
        usr_irq_req = 1'b0;

        // R4: captured level and vector unaffected by later changes
        @(negedge clk);
        usr_irq_req = 1'b1;
        usr_irq_lvl = 3'd3;
        usr_irq_vec = 32'h3333_AAAA;
        @(negedge clk);
        usr_irq_lvl = 3'd6;
        usr_irq_vec = 32'h6666_BBBB;
        @(negedge clk);
        check("R4 line keeps captured level", {25'd0, bus_irq_n}, {25'd0, line_for(3'd3)});
        start_cycle(3'd3);
        repeat (6) @(negedge clk);
        check("R4 vector keeps captured value", bus_data_out, 32'h3333_AAAA);
        end_cycle(pulses);
        check("R8 one ack pulse after R4 cycle", pulses, 32'd1);

        // R9: withdraw before any acknowledge
        @(negedge clk);
        usr_irq_req = 1'b1;
        usr_irq_lvl = 3'd7;
        @(negedge clk);
        check("R2 level 7 line", {25'd0, bus_irq_n}, 32'h3f);
        usr_irq_req = 1'b0;
        @(negedge clk);
        check("R9 early withdraw", {25'd0, bus_irq_n}, 32'h7f);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule